// File: doc/BRIEF.md
# Soft-Start and Hiccup Sequencer

This block is the digital sequencing core of a synchronous step-down regulator controller. It holds an internal ramp accumulator that stands in for the soft-start capacitor. The accumulator charges and discharges only on cycles where the tick enable is high. It charges in two stages, first with a large step and then with a small one. From the ramp level the block derives the gate-driver phase, the clamp applied to the error-amplifier reference, and whether reverse (sink) current is allowed.

The ramp stays at zero until both supply detectors report good and no inhibit is requested. While the ramp is still charging, an over-current flag only suppresses the high-side pulse for that cycle. Once start-up is complete, the same flag turns both drivers off and drains the ramp slowly. When the ramp has drained far enough, a new start-up begins. A thermal fault overrides everything else and drains the ramp with a large step. Restart after a thermal fault waits until the fault has cleared and the ramp is low.

Top module: `ramp_sequencer`

## Requirements
- R1: While the thermal flag is low and either supply flag is low or inhibit is high, a tick forces the ramp to 0.
- R2: During start-up, each tick adds 35 to the ramp while it is below 500 and 10 once it is at or above 500. After start-up, each tick adds 10. The ramp saturates at 4000. A cycle without a tick changes neither the ramp nor the sequencing state.
- R3: The phase code is 0 (both drivers off) when the ramp is below 500, 1 (low side held on) from 500 to 1099, and 2 (switching) at 1100 and above. It is 0 throughout hiccup and thermal shutdown.
- R4: Sink enable is 0 during start-up. It becomes 1 on the tick where the ramp reaches 3500 or more, and stays 1 until a fault, an inhibit or a supply loss.
- R5: During start-up, an over-current flag (peak or valley) never enters hiccup. Cycle-limit goes high while the phase is 2 and either flag is set.
- R6: After start-up, a ticked over-current flag enters hiccup. The hiccup output goes to 1, the phase goes to 0, and the ramp drops by 10 per tick.
- R7: When a hiccup discharge brings the ramp to 500 or below, hiccup ends and a new start-up begins from that level.
- R8: A ticked thermal flag forces the phase to 0 and sink enable to 0, and drops the ramp by 200 per tick, stopping at 0. This takes priority over every other input.
- R9: After the thermal flag clears, the block stays in shutdown, still draining, until the ramp is at or below 500. Only then does a new start-up begin.
- R10: The clamp output equals the smaller of the ramp and the reference input.
- R11: After reset, the ramp, clamp, phase, sink enable, hiccup and cycle-limit outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Ramp update enable |
| vcc_ok | input | 1 | Supply above its turn-on threshold |
| vin_ok | input | 1 | Input voltage above its turn-on threshold |
| inhibit | input | 1 | External disable request |
| oc_peak | input | 1 | High-side peak over-current flag |
| oc_valley | input | 1 | Low-side valley over-current flag |
| therm_fault | input | 1 | Over-temperature flag |
| ref_code | input | 12 | Programmed reference, 1 LSB = 1 mV |
| ramp_code | output | 12 | Soft-start ramp level, 1 LSB = 1 mV |
| clamp_code | output | 12 | Clamped error-amplifier reference |
| drv_phase | output | 2 | 0 off, 1 low side on, 2 switching |
| sink_en | output | 1 | Reverse current permitted |
| hiccup | output | 1 | Over-current hiccup in progress |
| cycle_limit | output | 1 | Suppress high-side pulse this cycle |

## Verification
The ramp is driven through a full start-up with one supply flag missing and then with both present. This separates the held-at-zero case from the two charge rates and the three phase bands. Over-current is applied once during the ramp and once after it, to tell cycle limiting apart from hiccup. A tick-free window with the flag set confirms that nothing moves without the enable. A long thermal fault drains the ramp to zero, while a short one clears with the ramp still high, which shows that restart waits for the ramp. Changing the reference moves the clamp from reference-limited to ramp-limited, and an inhibit in mid-ramp checks the forced discharge.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RAMP   = 3'd1,
    ST_RUN    = 3'd2,
    ST_HICCUP = 3'd3,
    ST_THERM  = 3'd4
  } seq_state_t;

  typedef enum logic [2:0] {
    OP_HOLD     = 3'd0,
    OP_CLEAR    = 3'd1,
    OP_CHARGE   = 3'd2,
    OP_DIS_SLOW = 3'd3,
    OP_DIS_FAST = 3'd4
  } ramp_op_t;

  typedef enum logic [1:0] {
    PH_OFF = 2'd0,
    PH_LOW = 2'd1,
    PH_SW  = 2'd2
  } drv_phase_t;
endpackage

// File: rtl/rs_rst_sync.sv
module rs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/rs_ramp.sv
module rs_ramp
  import ramp_seq_pkg::*;
#(
  parameter int W          = 12,
  parameter int STEP_FAST  = 35,
  parameter int STEP_SLOW  = 10,
  parameter int STEP_DISCH = 200,
  parameter int LVL_ENABLE = 500,
  parameter int LVL_TOP    = 4000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  ramp_op_t     op,
  input  seq_state_t   state_q,
  output logic [W-1:0] ramp_q,
  output logic [W-1:0] ramp_d
);
  localparam logic [W-1:0] K_FAST = W'(STEP_FAST);
  localparam logic [W-1:0] K_SLOW = W'(STEP_SLOW);
  localparam logic [W-1:0] K_DIS  = W'(STEP_DISCH);
  localparam logic [W-1:0] K_EN   = W'(LVL_ENABLE);
  localparam logic [W-1:0] K_TOP  = W'(LVL_TOP);

  logic [W-1:0] step;
  logic [W:0]   sum;

  // two-rate charge only applies while the start-up ramp is running
  always_comb begin
    step = ((state_q == ST_RAMP) && (ramp_q < K_EN)) ? K_FAST : K_SLOW;
    sum  = {1'b0, ramp_q} + {1'b0, step};
    unique case (op)
      OP_CLEAR:    ramp_d = '0;
      OP_CHARGE:   ramp_d = (sum > {1'b0, K_TOP}) ? K_TOP : sum[W-1:0];
      OP_DIS_SLOW: ramp_d = (ramp_q > K_SLOW) ? (ramp_q - K_SLOW) : '0;
      OP_DIS_FAST: ramp_d = (ramp_q > K_DIS) ? (ramp_q - K_DIS) : '0;
      default:     ramp_d = ramp_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ramp_q <= '0;
    else if (tick) ramp_q <= ramp_d;
  end
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
  import ramp_seq_pkg::*;
#(
  parameter int W          = 12,
  parameter int LVL_ENABLE = 500,
  parameter int LVL_DONE   = 3500
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run_ok,
  input  logic         oc_any,
  input  logic         therm,
  input  logic [W-1:0] ramp_q,
  input  logic [W-1:0] ramp_d,
  output seq_state_t   state_q,
  output ramp_op_t     op
);
  localparam logic [W-1:0] K_EN   = W'(LVL_ENABLE);
  localparam logic [W-1:0] K_DONE = W'(LVL_DONE);

  seq_state_t state_d;

  // ramp operation: depends on current ramp only
  always_comb begin
    op = OP_HOLD;
    if (therm)       op = OP_DIS_FAST;
    else if (!run_ok) op = OP_CLEAR;
    else begin
      unique case (state_q)
        ST_RAMP:   op = OP_CHARGE;
        ST_RUN:    op = oc_any ? OP_DIS_SLOW : OP_CHARGE;
        ST_HICCUP: op = OP_DIS_SLOW;
        ST_THERM:  op = (ramp_q <= K_EN) ? OP_HOLD : OP_DIS_FAST;
        default:   op = OP_HOLD;
      endcase
    end
  end

  // state transition: may look at the updated ramp
  always_comb begin
    state_d = state_q;
    if (therm)        state_d = ST_THERM;
    else if (!run_ok) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:   state_d = ST_RAMP;
        ST_RAMP:   if (ramp_d >= K_DONE) state_d = ST_RUN;
        ST_RUN:    if (oc_any) state_d = ST_HICCUP;
        ST_HICCUP: if (ramp_d <= K_EN) state_d = ST_RAMP;
        ST_THERM:  if (ramp_q <= K_EN) state_d = ST_RAMP;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= ST_IDLE;
    else if (tick) state_q <= state_d;
  end
endmodule

// File: rtl/rs_decode.sv
module rs_decode
  import ramp_seq_pkg::*;
#(
  parameter int W          = 12,
  parameter int LVL_ENABLE = 500,
  parameter int LVL_SWITCH = 1100
) (
  input  seq_state_t   state_q,
  input  logic [W-1:0] ramp_q,
  input  logic [W-1:0] ref_code,
  input  logic         oc_any,
  output logic [W-1:0] clamp_code,
  output logic [1:0]   drv_phase,
  output logic         sink_en,
  output logic         hiccup,
  output logic         cycle_limit
);
  localparam logic [W-1:0] K_EN = W'(LVL_ENABLE);
  localparam logic [W-1:0] K_SW = W'(LVL_SWITCH);

  drv_phase_t ph;
  logic       active;

  always_comb begin
    active = (state_q == ST_RAMP) || (state_q == ST_RUN);
    if (!active || (ramp_q < K_EN)) ph = PH_OFF;
    else if (ramp_q < K_SW)         ph = PH_LOW;
    else                            ph = PH_SW;
  end

  assign drv_phase   = ph;
  assign clamp_code  = (ramp_q < ref_code) ? ramp_q : ref_code;
  assign sink_en     = (state_q == ST_RUN);
  assign hiccup      = (state_q == ST_HICCUP);
  assign cycle_limit = (state_q == ST_RAMP) && (ph == PH_SW) && oc_any;
endmodule

// File: rtl/ramp_sequencer.sv
module ramp_sequencer
  import ramp_seq_pkg::*;
#(
  parameter int RAMP_W      = 12,
  parameter int STEP_FAST   = 35,
  parameter int STEP_SLOW   = 10,
  parameter int STEP_DISCH  = 200,
  parameter int LVL_ENABLE  = 500,
  parameter int LVL_SWITCH  = 1100,
  parameter int LVL_DONE    = 3500,
  parameter int LVL_TOP     = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              vcc_ok,
  input  logic              vin_ok,
  input  logic              inhibit,
  input  logic              oc_peak,
  input  logic              oc_valley,
  input  logic              therm_fault,
  input  logic [RAMP_W-1:0] ref_code,
  output logic [RAMP_W-1:0] ramp_code,
  output logic [RAMP_W-1:0] clamp_code,
  output logic [1:0]        drv_phase,
  output logic              sink_en,
  output logic              hiccup,
  output logic              cycle_limit
);
  logic              rst_n_int;
  logic              run_ok;
  logic              oc_any;
  seq_state_t        state_q;
  ramp_op_t          op;
  logic [RAMP_W-1:0] ramp_q;
  logic [RAMP_W-1:0] ramp_d;

  assign run_ok = vcc_ok && vin_ok && !inhibit;
  assign oc_any = oc_peak || oc_valley;

  rs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  rs_fsm #(
    .W(RAMP_W), .LVL_ENABLE(LVL_ENABLE), .LVL_DONE(LVL_DONE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n_int), .tick(tick), .run_ok(run_ok),
    .oc_any(oc_any), .therm(therm_fault), .ramp_q(ramp_q),
    .ramp_d(ramp_d), .state_q(state_q), .op(op)
  );

  rs_ramp #(
    .W(RAMP_W), .STEP_FAST(STEP_FAST), .STEP_SLOW(STEP_SLOW),
    .STEP_DISCH(STEP_DISCH), .LVL_ENABLE(LVL_ENABLE), .LVL_TOP(LVL_TOP)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n_int), .tick(tick), .op(op),
    .state_q(state_q), .ramp_q(ramp_q), .ramp_d(ramp_d)
  );

  rs_decode #(
    .W(RAMP_W), .LVL_ENABLE(LVL_ENABLE), .LVL_SWITCH(LVL_SWITCH)
  ) u_dec (
    .state_q(state_q), .ramp_q(ramp_q), .ref_code(ref_code),
    .oc_any(oc_any), .clamp_code(clamp_code), .drv_phase(drv_phase),
    .sink_en(sink_en), .hiccup(hiccup), .cycle_limit(cycle_limit)
  );

  assign ramp_code = ramp_q;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int W        = 12,
  parameter int LVL_DONE = 3500,
  parameter int LVL_TOP  = 4000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         vcc_ok,
  input logic         therm_fault,
  input logic         oc_peak,
  input logic         oc_valley,
  input logic [W-1:0] ref_code,
  input logic [W-1:0] ramp_code,
  input logic [W-1:0] clamp_code,
  input logic [1:0]   drv_phase,
  input logic         sink_en,
  input logic         hiccup,
  input logic         cycle_limit
);
  localparam logic [W-1:0] K_DONE = W'(LVL_DONE);
  localparam logic [W-1:0] K_TOP  = W'(LVL_TOP);

  assert_ramp_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_code <= K_TOP);

  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ramp_code));

  assert_supply_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !therm_fault && !vcc_ok) |=> (ramp_code == '0));

  assert_phase_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_phase != 2'd3);

  assert_sink_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sink_en |-> (ramp_code >= K_DONE));

  assert_limit_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_limit |-> (!hiccup && !sink_en && (oc_peak || oc_valley)));

  assert_hiccup_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hiccup |-> (drv_phase == 2'd0 && !sink_en));

  assert_therm_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && therm_fault) |=> (drv_phase == 2'd0 && !sink_en && !hiccup));

  assert_clamp_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_code <= ramp_code) && (clamp_code <= ref_code));
endmodule

bind ramp_sequencer rs_checker #(
  .W(RAMP_W), .LVL_DONE(LVL_DONE), .LVL_TOP(LVL_TOP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .vcc_ok(vcc_ok),
  .therm_fault(therm_fault), .oc_peak(oc_peak), .oc_valley(oc_valley),
  .ref_code(ref_code), .ramp_code(ramp_code), .clamp_code(clamp_code),
  .drv_phase(drv_phase), .sink_en(sink_en), .hiccup(hiccup),
  .cycle_limit(cycle_limit)
);

// File: tb/tb_ramp_sequencer.sv
`timescale 1ns/1ps
module tb_ramp_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, vcc_ok, vin_ok, inhibit, oc_peak, oc_valley, therm_fault;
  logic [11:0] ref_code;
  logic [11:0] ramp_code, clamp_code;
  logic [1:0]  drv_phase;
  logic        sink_en, hiccup, cycle_limit;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ramp_sequencer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vcc_ok(vcc_ok), .vin_ok(vin_ok),
    .inhibit(inhibit), .oc_peak(oc_peak), .oc_valley(oc_valley),
    .therm_fault(therm_fault), .ref_code(ref_code), .ramp_code(ramp_code),
    .clamp_code(clamp_code), .drv_phase(drv_phase), .sink_en(sink_en),
    .hiccup(hiccup), .cycle_limit(cycle_limit)
  );

  // behavioural reference: mode 0 idle, 1 start-up, 2 running, 3 hiccup, 4 thermal
  int m_mode = 0;
  int m_ramp = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0;
      m_ramp = 0;
    end else if (tick) begin
      if (therm_fault) begin
        m_mode = 4;
        m_ramp = (m_ramp > 200) ? m_ramp - 200 : 0;
      end else if (!(vcc_ok && vin_ok && !inhibit)) begin
        m_mode = 0;
        m_ramp = 0;
      end else if (m_mode == 0) begin
        m_mode = 1;
      end else if (m_mode == 1) begin
        m_ramp = m_ramp + ((m_ramp < 500) ? 35 : 10);
        if (m_ramp > 4000) m_ramp = 4000;
        if (m_ramp >= 3500) m_mode = 2;
      end else if (m_mode == 2) begin
        if (oc_peak || oc_valley) begin
          m_mode = 3;
          m_ramp = (m_ramp > 10) ? m_ramp - 10 : 0;
        end else begin
          m_ramp = (m_ramp + 10 > 4000) ? 4000 : m_ramp + 10;
        end
      end else if (m_mode == 3) begin
        m_ramp = (m_ramp > 10) ? m_ramp - 10 : 0;
        if (m_ramp <= 500) m_mode = 1;
      end else begin
        if (m_ramp <= 500) m_mode = 1;
        else m_ramp = (m_ramp > 200) ? m_ramp - 200 : 0;
      end
    end
  end

  function automatic int exp_phase();
    if (!(m_mode == 1 || m_mode == 2) || m_ramp < 500) return 0;
    if (m_ramp < 1100) return 1;
    return 2;
  endfunction

  task automatic check(string tag, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    int ph;
    ph = exp_phase();
    check("R2 ramp", int'(ramp_code), m_ramp);
    check("R3 phase", int'(drv_phase), ph);
    check("R4 sink", int'(sink_en), (m_mode == 2) ? 1 : 0);
    check("R6 hiccup", int'(hiccup), (m_mode == 3) ? 1 : 0);
    check("R10 clamp", int'(clamp_code), (m_ramp < int'(ref_code)) ? m_ramp : int'(ref_code));
    check("R5 cycle_limit", int'(cycle_limit),
          (m_mode == 1 && ph == 2 && (oc_peak || oc_valley)) ? 1 : 0);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    int saved;
    rst_n = 0; tick = 0; vcc_ok = 0; vin_ok = 0; inhibit = 0;
    oc_peak = 0; oc_valley = 0; therm_fault = 0; ref_code = 12'd600;
    cyc(4);
    check("R11 reset ramp", int'(ramp_code), 0);
    check("R11 reset phase", int'(drv_phase), 0);
    check("R11 reset flags", int'({sink_en, hiccup, cycle_limit}), 0);
    rst_n = 1;
    cyc(4);
    tick = 1; vcc_ok = 1;
    cyc(10);
    check("R1 one supply missing", int'(ramp_code), 0);
    vin_ok = 1;
    cyc(80);
    oc_peak = 1;
    cyc(5);
    check("R5 limit during start-up", int'(cycle_limit), 1);
    check("R5 no hiccup during start-up", int'(hiccup), 0);
    oc_peak = 0;
    cyc(320);
    check("R4 sink after start-up", int'(sink_en), 1);
    check("R10 clamp at reference", int'(clamp_code), 600);
    saved = int'(ramp_code);
    tick = 0; oc_valley = 1;
    cyc(10);
    check("R2 no tick holds ramp", int'(ramp_code), saved);
    check("R2 no tick holds state", int'(hiccup), 0);
    tick = 1;
    cyc(1);
    check("R6 hiccup entered", int'(hiccup), 1);
    check("R6 drivers off", int'(drv_phase), 0);
    oc_valley = 0;
    cyc(400);
    check("R7 hiccup ended", int'(hiccup), 0);
    cyc(400);
    therm_fault = 1;
    cyc(30);
    check("R8 thermal drain", int'(ramp_code), 0);
    check("R8 thermal off", int'(drv_phase), 0);
    therm_fault = 0;
    cyc(200);
    therm_fault = 1;
    cyc(3);
    therm_fault = 0;
    cyc(1);
    check("R9 waits for ramp", int'(drv_phase), 0);
    check("R9 sink off", int'(sink_en), 0);
    cyc(20);
    ref_code = 12'd4095;
    cyc(5);
    check("R10 clamp follows ramp", int'(clamp_code), int'(ramp_code));
    inhibit = 1;
    cyc(3);
    check("R1 inhibit clears ramp", int'(ramp_code), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end
endmodule